// File: doc/BRIEF.md
# Lockable Region Address Remapper

This block sits beside a processor core on both its instruction-fetch address path and its data address path. When an address falls inside a programmed, enabled region, the block replaces it with an address in another region. The replacement keeps the offset within the region and takes the upper bits from a remap base. Addresses that hit no enabled region leave the block unchanged. Translation is combinational, so it adds no cycle to either path.

Each translation slot holds one configuration for the instruction path and a separate one for the data path. A configuration stores its region base and size together in a single naturally aligned power-of-two word. In that word the low bits hold a run of ones, and the first clear bit above that run marks the region size.

Each configuration also has a write-permission bit. Software clears this bit to freeze the configuration, and the configuration then stays frozen until the next reset. All configuration is reached through a small word-indexed register port with single-cycle writes and registered reads.

Top module: `addr_remap_unit`

## Requirements
- R1: Configuration word index = slot*8 + path*4 + field, where path 0 is the instruction path and path 1 the data path. Field 0 is the match word, field 1 the remap base, field 2 the enable (bit 0) and field 3 the write permission (bit 0). A write with `cfg_we` high takes effect at the clock edge. `cfg_rdata` shows the stored word of `cfg_idx` one clock edge after the index is applied, and 1-bit fields read back zero-extended.
- R2: The region is decoded from the match word M. The offset mask is M XOR (M+1), which covers every bit up to and including the lowest clear bit of M. The region size is that mask plus one, the base is M with the mask bits cleared, and the smallest region is 2 bytes.
- R3: An address inside an enabled region leaves as (remap AND NOT mask) OR (address AND mask), in the same cycle it is presented.
- R4: An address that hits no enabled region of its own path leaves unchanged.
- R5: Write permission resets to 1. Writing 0 to it while it is 1 clears it, and writing 1 to it while it is 1 keeps it at 1. Once it is 0, only reset sets it again.
- R6: While a configuration's write permission is 0, writes to its match word, remap base, enable and write permission leave all four unchanged.
- R7: Reset clears every match word, remap base and enable to 0. A configuration whose enable is 0 never translates an address, whatever its match word.
- R8: When an address hits enabled regions in both slots, slot 0 supplies the translation.
- R9: The instruction path is compared only against instruction-path configurations, and the data path only against data-path configurations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 4 | Configuration word index (default of two slots) |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Registered read data for the previous `cfg_idx` |
| ibus_addr_i | input | 32 | Instruction-path address before translation |
| ibus_addr_o | output | 32 | Instruction-path address after translation |
| dbus_addr_i | input | 32 | Data-path address before translation |
| dbus_addr_o | output | 32 | Data-path address after translation |

## Verification
A wrong region mask shows up as soon as an address crosses the region edge. A mask one bit too wide or too narrow translates the first address just outside the region, or passes through the last address inside it. The bench therefore sweeps every region size from 2 bytes to 64 KB and probes both edges and the midpoint, all in the same cycle as the address is applied.

A lost lock or a write that leaks past the lock does not show in any address until translation is probed again. So after each blocked write the bench reads the frozen words back on the next cycle and then probes translation again. A path mix-up shows at once, because the bench keeps the other path active with the same address while one path is configured.

// File: rtl/remap_pkg.sv
package remap_pkg;
  localparam int unsigned XLEN          = 32;
  localparam int unsigned NUM_PATHS     = 2;
  localparam int unsigned FIELDS        = 4;
  localparam int unsigned FIELD_SEL_W   = $clog2(FIELDS);
  localparam int unsigned PATH_IFETCH   = 0;
  localparam int unsigned PATH_DATA     = 1;

  typedef logic [XLEN-1:0] word_t;

  typedef enum logic [FIELD_SEL_W-1:0] {
    FLD_MATCH  = 2'd0,
    FLD_REMAP  = 2'd1,
    FLD_ENABLE = 2'd2,
    FLD_PERMIT = 2'd3
  } field_sel_e;

  typedef struct packed {
    word_t match;
    word_t remap;
    logic  enable;
    logic  permit;
  } path_cfg_t;
endpackage

// File: rtl/remap_cfg_regs.sv
module remap_cfg_regs
  import remap_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  field_sel_e wr_sel,
  input  word_t      wr_data,
  output path_cfg_t  cfg
);
  path_cfg_t cfg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q.match  <= '0;
      cfg_q.remap  <= '0;
      cfg_q.enable <= 1'b0;
      cfg_q.permit <= 1'b1;
    end else if (wr_en && cfg_q.permit) begin
      case (wr_sel)
        FLD_MATCH:  cfg_q.match  <= wr_data;
        FLD_REMAP:  cfg_q.remap  <= wr_data;
        FLD_ENABLE: cfg_q.enable <= wr_data[0];
        FLD_PERMIT: cfg_q.permit <= wr_data[0];
        default:    cfg_q.permit <= cfg_q.permit;
      endcase
    end
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/remap_region_check.sv
module remap_region_check
  import remap_pkg::*;
(
  input  path_cfg_t cfg,
  input  word_t     addr_in,
  output logic      hit,
  output word_t     addr_xlat
);
  word_t span;

  always_comb begin
    span      = cfg.match ^ (cfg.match + word_t'(1));
    hit       = cfg.enable && ((addr_in & ~span) == (cfg.match & ~span));
    addr_xlat = (cfg.remap & ~span) | (addr_in & span);
  end
endmodule

// File: rtl/remap_path_xlate.sv
module remap_path_xlate
  import remap_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 2
) (
  input  path_cfg_t [NUM_SLOTS-1:0] slot_cfg,
  input  word_t                     addr_in,
  output word_t                     addr_out
);
  logic  [NUM_SLOTS-1:0] hit;
  word_t                 xlat [NUM_SLOTS];

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    remap_region_check u_check (
      .cfg      (slot_cfg[s]),
      .addr_in  (addr_in),
      .hit      (hit[s]),
      .addr_xlat(xlat[s])
    );
  end

  always_comb begin
    addr_out = addr_in;
    for (int s = NUM_SLOTS - 1; s >= 0; s--) begin
      if (hit[s]) addr_out = xlat[s];
    end
  end
endmodule

// File: rtl/addr_remap_unit.sv
module addr_remap_unit
  import remap_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 2,
  localparam int unsigned NUM_CFG   = NUM_SLOTS * NUM_PATHS,
  localparam int unsigned NUM_WORDS = NUM_CFG * FIELDS,
  localparam int unsigned IDX_W     = $clog2(NUM_WORDS),
  localparam int unsigned CFG_SEL_W = IDX_W - FIELD_SEL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [XLEN-1:0]  cfg_wdata,
  output logic [XLEN-1:0]  cfg_rdata,
  input  logic [XLEN-1:0]  ibus_addr_i,
  output logic [XLEN-1:0]  ibus_addr_o,
  input  logic [XLEN-1:0]  dbus_addr_i,
  output logic [XLEN-1:0]  dbus_addr_o
);
  path_cfg_t [NUM_CFG-1:0]   cfg_all;
  path_cfg_t [NUM_SLOTS-1:0] ifetch_cfg;
  path_cfg_t [NUM_SLOTS-1:0] data_cfg;

  logic [CFG_SEL_W-1:0] cfg_sel;
  field_sel_e           fld_sel;
  word_t                rd_word;
  word_t                rdata_q;

  assign cfg_sel = cfg_idx[IDX_W-1:FIELD_SEL_W];
  assign fld_sel = field_sel_e'(cfg_idx[FIELD_SEL_W-1:0]);

  for (genvar c = 0; c < NUM_CFG; c++) begin : g_cfg
    remap_cfg_regs u_regs (
      .clk    (clk),
      .rst    (rst),
      .wr_en  (cfg_we && (cfg_sel == CFG_SEL_W'(c))),
      .wr_sel (fld_sel),
      .wr_data(cfg_wdata),
      .cfg    (cfg_all[c])
    );
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_split
    assign ifetch_cfg[s] = cfg_all[s*NUM_PATHS + PATH_IFETCH];
    assign data_cfg[s]   = cfg_all[s*NUM_PATHS + PATH_DATA];
  end

  always_comb begin
    rd_word = '0;
    for (int c = 0; c < NUM_CFG; c++) begin
      if (cfg_sel == CFG_SEL_W'(c)) begin
        case (fld_sel)
          FLD_MATCH:  rd_word = cfg_all[c].match;
          FLD_REMAP:  rd_word = cfg_all[c].remap;
          FLD_ENABLE: rd_word = word_t'(cfg_all[c].enable);
          FLD_PERMIT: rd_word = word_t'(cfg_all[c].permit);
          default:    rd_word = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_word;
  end
  assign cfg_rdata = rdata_q;

  remap_path_xlate #(.NUM_SLOTS(NUM_SLOTS)) u_ifetch (
    .slot_cfg(ifetch_cfg),
    .addr_in (ibus_addr_i),
    .addr_out(ibus_addr_o)
  );

  remap_path_xlate #(.NUM_SLOTS(NUM_SLOTS)) u_data (
    .slot_cfg(data_cfg),
    .addr_in (dbus_addr_i),
    .addr_out(dbus_addr_o)
  );
endmodule

// File: rtl/remap_checker.sv
module remap_checker
  import remap_pkg::*;
#(
  parameter int unsigned NUM_CFG = 4
) (
  input logic                    clk,
  input logic                    rst,
  input path_cfg_t [NUM_CFG-1:0] cfg_all,
  input logic [XLEN-1:0]         ibus_i,
  input logic [XLEN-1:0]         ibus_o,
  input logic [XLEN-1:0]         dbus_i,
  input logic [XLEN-1:0]         dbus_o
);
  logic any_if_en;
  logic any_d_en;

  always_comb begin
    any_if_en = 1'b0;
    any_d_en  = 1'b0;
    for (int c = 0; c < NUM_CFG; c++) begin
      if (c % NUM_PATHS == PATH_IFETCH) any_if_en = any_if_en | cfg_all[c].enable;
      else                              any_d_en  = any_d_en  | cfg_all[c].enable;
    end
  end

  for (genvar c = 0; c < NUM_CFG; c++) begin : g_pair
    p_lock_sticky_r5: assert property (@(posedge clk) disable iff (rst)
      !cfg_all[c].permit |=> !cfg_all[c].permit);

    p_locked_frozen_r6: assert property (@(posedge clk) disable iff (rst)
      !cfg_all[c].permit |=> $stable(cfg_all[c]));

    p_reset_state_r7: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!cfg_all[c].enable && cfg_all[c].permit &&
                      cfg_all[c].match == '0 && cfg_all[c].remap == '0));
  end

  p_ifetch_bypass_r4: assert property (@(posedge clk) disable iff (rst)
    !any_if_en |-> ibus_o == ibus_i);

  p_data_bypass_r4: assert property (@(posedge clk) disable iff (rst)
    !any_d_en |-> dbus_o == dbus_i);

  p_offset_lsb_r3: assert property (@(posedge clk) disable iff (rst)
    (ibus_o[0] == ibus_i[0]) && (dbus_o[0] == dbus_i[0]));
endmodule

bind addr_remap_unit remap_checker #(.NUM_CFG(NUM_CFG)) u_remap_chk (
  .clk   (clk),
  .rst   (rst),
  .cfg_all(cfg_all),
  .ibus_i(ibus_addr_i),
  .ibus_o(ibus_addr_o),
  .dbus_i(dbus_addr_i),
  .dbus_o(dbus_addr_o)
);

// File: tb/sim_addr_remap_unit.sv
`timescale 1ns/1ps
module sim_addr_remap_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_idx = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [31:0] ibus_addr_i = '0;
  logic [31:0] ibus_addr_o;
  logic [31:0] dbus_addr_i = '0;
  logic [31:0] dbus_addr_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  addr_remap_unit #(.NUM_SLOTS(2)) u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .ibus_addr_i(ibus_addr_i), .ibus_addr_o(ibus_addr_o),
    .dbus_addr_i(dbus_addr_i), .dbus_addr_o(dbus_addr_o)
  );

  function automatic logic [3:0] widx(input int slot, input int path, input int fld);
    return 4'(slot * 8 + path * 4 + fld);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] idx, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] idx, output logic [31:0] data);
    @(negedge clk);
    cfg_idx = idx;
    @(posedge clk);
    #1 data = cfg_rdata;
  endtask

  task automatic probe(input logic [31:0] ia, input logic [31:0] da,
                       output logic [31:0] io, output logic [31:0] dout);
    @(negedge clk);
    ibus_addr_i = ia; dbus_addr_i = da;
    #1 io = ibus_addr_o; dout = dbus_addr_o;
  endtask

  function automatic logic [31:0] expect_xl(input logic [31:0] a, input logic [31:0] base,
                                            input logic [31:0] size, input logic [31:0] remap);
    if (a >= base && a - base < size) return remap + (a - base);
    return a;
  endfunction

  initial begin
    logic [31:0] v, io, dout;
    logic [31:0] base, size, remap, m;
    logic [31:0] pts [5];

    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 R5 R7: reset contents of every word
    for (int s = 0; s < 2; s++)
      for (int p = 0; p < 2; p++)
        for (int f = 0; f < 4; f++) begin
          rd(widx(s, p, f), v);
          chk((f == 3) ? "R5 permit reset" : "R7 reset value", v, (f == 3) ? 32'd1 : 32'd0);
        end

    // R4 R7: nothing enabled, including a match word programmed without enable
    wr(widx(0, 0, 0), 32'h0000_0FFF);
    wr(widx(0, 0, 1), 32'h7000_0000);
    probe(32'h0000_0123, 32'hDEAD_BEEF, io, dout);
    chk("R7 disabled never matches", io, 32'h0000_0123);
    chk("R4 passthrough", dout, 32'hDEAD_BEEF);

    // R2 R3 R9: sweep every region size 2 B .. 64 KB on slot 0 instruction path
    base  = 32'h9000_0000;
    remap = 32'h2000_0000;
    wr(widx(0, 0, 1), remap);
    wr(widx(0, 0, 2), 32'd1);
    for (int i = 1; i <= 16; i++) begin
      size = 32'd1 << i;
      m = base | ((size - 1) >> 1);
      wr(widx(0, 0, 0), m);
      pts[0] = base; pts[1] = base + size - 1; pts[2] = base + size;
      pts[3] = base - 1; pts[4] = base + (size >> 1);
      for (int k = 0; k < 5; k++) begin
        probe(pts[k], pts[k], io, dout);
        chk("R2 R3 region translate", io, expect_xl(pts[k], base, size, remap));
        chk("R9 data path untouched", dout, pts[k]);
      end
    end

    // R1: readback of programmed words
    rd(widx(0, 0, 0), v);
    chk("R1 readback match", v, 32'h9000_7FFF);
    rd(widx(0, 0, 1), v);
    chk("R1 readback remap", v, 32'h2000_0000);

    // R9: data path slot 1, instruction path does not see it
    wr(widx(1, 1, 0), 32'h4000_07FF);
    wr(widx(1, 1, 1), 32'h0001_0000);
    wr(widx(1, 1, 2), 32'd1);
    probe(32'h4000_0123, 32'h4000_0123, io, dout);
    chk("R9 data translated", dout, 32'h0001_0123);
    chk("R9 ifetch ignores data cfg", io, 32'h4000_0123);
    probe(32'h0, 32'h4000_1000, io, dout);
    chk("R4 past region end", dout, 32'h4000_1000);

    // R8: overlapping slots on the instruction path
    wr(widx(1, 0, 0), 32'h9000_007F);
    wr(widx(1, 0, 1), 32'h3000_0000);
    wr(widx(1, 0, 2), 32'd1);
    probe(32'h9000_0010, 32'h0, io, dout);
    chk("R8 slot 0 priority", io, 32'h2000_0010);
    wr(widx(0, 0, 2), 32'd0);
    probe(32'h9000_0010, 32'h0, io, dout);
    chk("R8 slot 1 when slot 0 off", io, 32'h3000_0010);
    probe(32'h9000_0200, 32'h0, io, dout);
    chk("R7 disabled slot passthrough", io, 32'h9000_0200);

    // R5 R6: lock the data path of slot 1
    wr(widx(1, 1, 3), 32'd1);
    rd(widx(1, 1, 3), v);
    chk("R5 permit write 1 keeps 1", v, 32'd1);
    wr(widx(1, 1, 3), 32'd0);
    rd(widx(1, 1, 3), v);
    chk("R5 permit cleared", v, 32'd0);
    wr(widx(1, 1, 0), 32'hFFFF_FFFF);
    wr(widx(1, 1, 1), 32'h5555_0000);
    wr(widx(1, 1, 2), 32'd0);
    wr(widx(1, 1, 3), 32'd1);
    rd(widx(1, 1, 0), v);
    chk("R6 locked match kept", v, 32'h4000_07FF);
    rd(widx(1, 1, 1), v);
    chk("R6 locked remap kept", v, 32'h0001_0000);
    rd(widx(1, 1, 2), v);
    chk("R6 locked enable kept", v, 32'd1);
    rd(widx(1, 1, 3), v);
    chk("R5 permit stays 0", v, 32'd0);
    probe(32'h0, 32'h4000_07FE, io, dout);
    chk("R6 locked translation kept", dout, 32'h0001_07FE);

    // R1: neighbouring configuration stays writable
    wr(widx(1, 0, 1), 32'h3100_0000);
    rd(widx(1, 0, 1), v);
    chk("R1 other cfg writable", v, 32'h3100_0000);
    probe(32'h9000_0044, 32'h0, io, dout);
    chk("R3 new remap used", io, 32'h3100_0044);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule